// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a simple request/acknowledge port inside the chip and an external byte-wide asynchronous static RAM with 32K locations. The RAM has active-low select, read-enable and write-enable strobes and one bidirectional data bus. The controller takes one read or one write at a time. It registers every strobe and drives them in phases counted in clock cycles. The phase lengths come from the RAM speed grade and the clock period, both given as parameters, so the access, pulse-width, setup and bus-release minimums hold for any supported grade.

The controller exposes the data bus as a separate output value, an output enable and an input value, so that a pad cell outside the block joins them. Reads return the captured byte together with a one-cycle `done` pulse. Writes also end with a `done` pulse. The read-enable strobe stays high for the whole of every write, so the RAM's own drivers are never on while the write pulse is active. After each read a turnaround gap lets the RAM release the bus before the controller can drive it again.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset the RAM select, read-enable and write-enable outputs are high, the data driver is off, `done` is low and `req_ready` is high.
- R2: A read drives select low, read-enable low and write-enable high. A write drives select low, write-enable low and read-enable high. Read-enable and write-enable are never low in the same cycle.
- R3: A read keeps its strobes and address for CYC_RD = ceil(max(cycle time, address access, read-enable access) / clock period) cycles. The data bus is sampled at the edge that ends this window, and the sampled byte appears on `rdata` in the cycle in which `done` is high. For the 70 ns grade at a 20 ns clock, CYC_RD is 4 and `done` follows the accepting edge by 4 edges.
- R4: A write holds write-enable low for CYC_WP = ceil(max(write pulse, select-to-end, address-to-end, data setup) / clock period) cycles, with select low and the data driver on throughout (3 cycles for the 70 ns grade at 20 ns).
- R5: Address, write data and the data driver stay unchanged from the start of the write pulse through at least one cycle after write-enable rises. The whole write occupies at least ceil(write cycle time / clock period) cycles before `done`, which follows the accepting edge by 4 edges for the 70 ns grade at 20 ns.
- R6: After a read, `req_ready` stays low for CYC_TURN = max(1, ceil(bus release time / clock period)) cycles, starting with the `done` cycle (2 cycles at 70 ns / 20 ns). The data driver never turns on while read strobes are active, or less than the bus release time (25 ns for the 70 ns grade) after they end.
- R7: A request is accepted only in a cycle where `req_valid` and `req_ready` are both high. A request offered while `req_ready` is low has no effect on the RAM. Each accepted request produces exactly one `done` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| req_ready | output | 1 | Controller idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Byte captured by the last read |
| ram_addr | output | ADDR_W | RAM address lines |
| ram_cs_n | output | 1 | RAM select, active low |
| ram_oe_n | output | 1 | RAM read enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dq_o | output | DATA_W | Value driven onto the RAM data bus |
| ram_dq_oe | output | 1 | Data bus driver enable |
| ram_dq_i | input | DATA_W | Value seen on the RAM data bus |

## Verification
The end of a read and the start of a following write can meet in the same cycle. The controller finishes the read and releases its strobes while a write request is already waiting, and that write must not be taken until the bus release gap has passed. The bench provokes this by keeping `req_valid` high and switching the request to a write straight after the read is accepted. A RAM model in the bench timestamps the end of every read and reports any driver enable that comes less than the release time after it. The same model checks the write pulse width and returns a bad byte whenever data is sampled before the access time has passed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_TURN,
      ST_WPULSE,
      ST_WHOLD
   } seq_state_e;

   typedef enum int {
      TM_RC,
      TM_AA,
      TM_AOE,
      TM_HZ,
      TM_WC,
      TM_CW,
      TM_AW,
      TM_WP,
      TM_DW
   } tm_item_e;

   function automatic bit grade_ok(input int grade);
      return (grade == 50) || (grade == 70) || (grade == 85) || (grade == 100);
   endfunction

   // Minimum (or bus release) times in ns for each supported speed grade.
   function automatic int grade_ns(input int grade, input tm_item_e item);
      int r;
      r = grade;
      if (item != TM_RC && item != TM_AA && item != TM_WC) begin
         case (grade)
            50:      case (item) TM_AOE: r = 25; TM_HZ: r = 20; TM_WP: r = 30; TM_DW: r = 25; default: r = 40; endcase
            70:      case (item) TM_AOE: r = 35; TM_HZ: r = 25; TM_WP: r = 50; TM_DW: r = 30; default: r = 60; endcase
            85:      case (item) TM_AOE: r = 40; TM_HZ: r = 30; TM_WP: r = 60; TM_DW: r = 35; default: r = 70; endcase
            default: case (item) TM_AOE: r = 50; TM_HZ: r = 30; TM_WP: r = 70; TM_DW: r = 40; default: r = 80; endcase
         endcase
      end
      return r;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int ns_to_cyc(input int ns, input int period);
      int c;
      c = (ns + period - 1) / period;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int CYC_RD   = 7,
   parameter int CYC_WP   = 6,
   parameter int CYC_WREC = 1,
   parameter int CYC_TURN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tm_zero,
   output logic             tm_load,
   output logic [CNT_W-1:0] tm_val,
   output logic             req_ready,
   output logic             accept,
   output logic             rd_end,
   output logic             wr_end,
   output logic             cs_n,
   output logic             oe_n,
   output logic             we_n
);

   localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(CYC_RD - 1);
   localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(CYC_WP - 1);
   localparam logic [CNT_W-1:0] WREC_LD = CNT_W'(CYC_WREC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(CYC_TURN - 1);

   seq_state_e st_q, st_d;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_ready && req_valid;

   always_comb begin
      st_d    = st_q;
      tm_load = 1'b0;
      tm_val  = '0;
      rd_end  = 1'b0;
      wr_end  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               tm_load = 1'b1;
               tm_val  = req_write ? WP_LD : RD_LD;
               st_d    = req_write ? ST_WPULSE : ST_READ;
            end
         end
         ST_READ: begin
            if (tm_zero) begin
               rd_end  = 1'b1;
               tm_load = 1'b1;
               tm_val  = TURN_LD;
               st_d    = ST_TURN;
            end
         end
         ST_TURN: begin
            if (tm_zero) begin
               st_d = ST_IDLE;
            end
         end
         ST_WPULSE: begin
            if (tm_zero) begin
               tm_load = 1'b1;
               tm_val  = WREC_LD;
               st_d    = ST_WHOLD;
            end
         end
         ST_WHOLD: begin
            if (tm_zero) begin
               wr_end = 1'b1;
               st_d   = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   // Strobes are registered images of the next state: no glitches at the pins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         cs_n <= 1'b1;
         oe_n <= 1'b1;
         we_n <= 1'b1;
      end else begin
         st_q <= st_d;
         cs_n <= !((st_d == ST_READ) || (st_d == ST_WPULSE));
         oe_n <= !(st_d == ST_READ);
         we_n <= !(st_d == ST_WPULSE);
      end
   end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              rd_end,
   input  logic              wr_end,
   input  logic [DATA_W-1:0] ram_dq_i,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_dq_o,
   output logic              ram_dq_oe,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_addr  <= '0;
         ram_dq_o  <= '0;
         ram_dq_oe <= 1'b0;
         rdata     <= '0;
         done      <= 1'b0;
      end else begin
         done <= rd_end || wr_end;
         if (accept) begin
            ram_addr <= req_addr;
            if (req_write) begin
               ram_dq_o  <= req_wdata;
               ram_dq_oe <= 1'b1;
            end
         end
         if (wr_end) begin
            ram_dq_oe <= 1'b0;
         end
         if (rd_end) begin
            rdata <= ram_dq_i;
         end
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 10,
   parameter int SPEED_NS      = 70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_cs_n,
   output logic              ram_oe_n,
   output logic              ram_we_n,
   output logic [DATA_W-1:0] ram_dq_o,
   output logic              ram_dq_oe,
   input  logic [DATA_W-1:0] ram_dq_i
);

   localparam int NS_RD = max_of(max_of(grade_ns(SPEED_NS, TM_RC), grade_ns(SPEED_NS, TM_AA)),
                                 grade_ns(SPEED_NS, TM_AOE));
   localparam int NS_WP = max_of(max_of(grade_ns(SPEED_NS, TM_WP), grade_ns(SPEED_NS, TM_CW)),
                                 max_of(grade_ns(SPEED_NS, TM_AW), grade_ns(SPEED_NS, TM_DW)));
   localparam int CYC_RD   = ns_to_cyc(NS_RD, CLK_PERIOD_NS);
   localparam int CYC_WP   = ns_to_cyc(NS_WP, CLK_PERIOD_NS);
   localparam int CYC_WC   = ns_to_cyc(grade_ns(SPEED_NS, TM_WC), CLK_PERIOD_NS);
   localparam int CYC_WREC = max_of(1, CYC_WC - CYC_WP);
   localparam int CYC_TURN = ns_to_cyc(grade_ns(SPEED_NS, TM_HZ), CLK_PERIOD_NS);
   localparam int CYC_MAX  = max_of(max_of(CYC_RD, CYC_WP), max_of(CYC_WREC, CYC_TURN));
   localparam int CNT_W    = max_of(1, $clog2(CYC_MAX + 1));

   if (!grade_ok(SPEED_NS)) begin : g_bad_grade
      $error("sram_async_ctrl: SPEED_NS must be 50, 70, 85 or 100");
   end
   if (CLK_PERIOD_NS < 1) begin : g_bad_clk
      $error("sram_async_ctrl: CLK_PERIOD_NS must be positive");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_async_ctrl: ADDR_W and DATA_W must be positive");
   end

   logic             tm_load, tm_zero, accept, rd_end, wr_end;
   logic [CNT_W-1:0] tm_val;

   sram_phase_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .zero     (tm_zero)
   );

   sram_seq_fsm #(
      .CNT_W    (CNT_W),
      .CYC_RD   (CYC_RD),
      .CYC_WP   (CYC_WP),
      .CYC_WREC (CYC_WREC),
      .CYC_TURN (CYC_TURN)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .tm_zero   (tm_zero),
      .tm_load   (tm_load),
      .tm_val    (tm_val),
      .req_ready (req_ready),
      .accept    (accept),
      .rd_end    (rd_end),
      .wr_end    (wr_end),
      .cs_n      (ram_cs_n),
      .oe_n      (ram_oe_n),
      .we_n      (ram_we_n)
   );

   sram_data_path #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rd_end    (rd_end),
      .wr_end    (wr_end),
      .ram_dq_i  (ram_dq_i),
      .ram_addr  (ram_addr),
      .ram_dq_o  (ram_dq_o),
      .ram_dq_oe (ram_dq_oe),
      .rdata     (rdata),
      .done      (done)
   );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
   parameter int ADDR_W   = 15,
   parameter int DATA_W   = 8,
   parameter int CYC_RD   = 7,
   parameter int CYC_WP   = 6,
   parameter int CYC_TURN = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic [ADDR_W-1:0] ram_addr,
   input logic              ram_cs_n,
   input logic              ram_oe_n,
   input logic              ram_we_n,
   input logic [DATA_W-1:0] ram_dq_o,
   input logic              ram_dq_oe
);

   logic [15:0] we_lo_q, oe_lo_q, oe_off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_q  <= '0;
         oe_lo_q  <= '0;
         oe_off_q <= 16'hFFFF;
      end else begin
         we_lo_q  <= ram_we_n ? 16'd0 : ((we_lo_q == 16'hFFFF) ? we_lo_q : we_lo_q + 16'd1);
         oe_lo_q  <= ram_oe_n ? 16'd0 : ((oe_lo_q == 16'hFFFF) ? oe_lo_q : oe_lo_q + 16'd1);
         oe_off_q <= !ram_oe_n ? 16'd0 : ((oe_off_q == 16'hFFFF) ? oe_off_q : oe_off_q + 16'd1);
      end
   end

   p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ram_oe_n && !ram_we_n));

   p_read_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_oe_n) |-> (oe_lo_q >= 16'(CYC_RD)));

   p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we_n) |-> (we_lo_q >= 16'(CYC_WP)));

   p_we_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (!ram_cs_n && ram_dq_oe));

   p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we_n) |-> ($stable(ram_addr) && $stable(ram_dq_o) && ram_dq_oe));

   p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_dq_oe) |-> (ram_oe_n && (oe_off_q >= 16'(CYC_TURN))));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_cs_n |-> !req_ready);

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CYC_RD   (CYC_RD),
   .CYC_WP   (CYC_WP),
   .CYC_TURN (CYC_TURN)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .done      (done),
   .ram_addr  (ram_addr),
   .ram_cs_n  (ram_cs_n),
   .ram_oe_n  (ram_oe_n),
   .ram_we_n  (ram_we_n),
   .ram_dq_o  (ram_dq_o),
   .ram_dq_oe (ram_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

   localparam int T      = 20;  // 50 MHz
   localparam int AA_NS  = 70;
   localparam int WP_NS  = 50;
   localparam int CW_NS  = 60;
   localparam int HZ_NS  = 25;
   localparam int RD_LAT = 5;   // negedges from accept to done, read
   localparam int WR_LAT = 5;   // same, write

   typedef struct packed {
      logic        wr;
      logic [14:0] addr;
      logic [7:0]  data;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 15'h0000, 8'h5A}, '{1'b1, 15'h7FFF, 8'hC3}, '{1'b1, 15'h1234, 8'h01},
      '{1'b1, 15'h4AA5, 8'hFF}, '{1'b0, 15'h0000, 8'h5A}, '{1'b0, 15'h7FFF, 8'hC3},
      '{1'b0, 15'h1234, 8'h01}, '{1'b0, 15'h4AA5, 8'hFF}, '{1'b1, 15'h1234, 8'h7E},
      '{1'b0, 15'h1234, 8'h7E}, '{1'b1, 15'h0001, 8'h00}, '{1'b0, 15'h0001, 8'h00},
      '{1'b0, 15'h7FFF, 8'hC3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, done;
   logic [7:0]  rdata;
   logic [14:0] ram_addr;
   logic        ram_cs_n, ram_oe_n, ram_we_n, ram_dq_oe;
   logic [7:0]  ram_dq_o;
   logic [7:0]  ram_dq_i = 8'h00;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit fin = 1'b0;

   always #(T/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sram_async_ctrl #(
      .CLK_PERIOD_NS (T),
      .SPEED_NS      (70)
   ) i_sram_async_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .done      (done),
      .rdata     (rdata),
      .ram_addr  (ram_addr),
      .ram_cs_n  (ram_cs_n),
      .ram_oe_n  (ram_oe_n),
      .ram_we_n  (ram_we_n),
      .ram_dq_o  (ram_dq_o),
      .ram_dq_oe (ram_dq_oe),
      .ram_dq_i  (ram_dq_i)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_min(input string tag, input int act, input int lo);
      checks++;
      if (act < lo) begin
         errors++;
         $display("FAIL %s actual=%0d expected>=%0d", tag, act, lo);
      end
   endtask

   // ---------------- behavioural RAM with timing checks ----------------
   logic [7:0]  mem [logic [14:0]];
   bit          prev_rd = 0, prev_wr = 0, have_rd = 0;
   int          rd_start = 0, rd_end_cyc = 0, we_start = 0;
   logic [14:0] prev_addr = '0, w_addr = '0;
   logic [7:0]  w_data = '0;

   always @(negedge clk) begin
      bit rd_act, wr_act;
      if (rst_n) begin
         rd_act = !ram_cs_n && !ram_oe_n && ram_we_n;
         wr_act = !ram_cs_n && !ram_we_n;
         if (!ram_oe_n && !ram_we_n) chk("R2 oe/we both low", 1, 0);
         if (!ram_we_n && ram_cs_n) chk("R4 we low while deselected", 1, 0);
         if (rd_act && (!prev_rd || ram_addr != prev_addr)) rd_start = cyc;
         if (prev_rd && !rd_act) begin
            rd_end_cyc = cyc;
            have_rd = 1;
         end
         if (ram_dq_oe && (rd_act || (have_rd && (cyc - rd_end_cyc) * T < HZ_NS)))
            chk("R6 bus contention", 1, 0);
         if (rd_act && ((cyc - rd_start + 1) * T >= AA_NS))
            ram_dq_i = mem.exists(ram_addr) ? mem[ram_addr] : 8'h00;
         else
            ram_dq_i = 8'hEE;
         if (wr_act) begin
            if (!prev_wr) begin
               we_start = cyc;
               w_addr   = ram_addr;
               w_data   = ram_dq_o;
            end
            if (!ram_dq_oe || ram_addr != w_addr || ram_dq_o != w_data)
               chk("R4 data/addr during pulse", 1, 0);
         end
         if (prev_wr && !wr_act) begin
            chk_min("R4 write pulse width ns", (cyc - we_start) * T, WP_NS);
            chk_min("R4 select to end ns", (cyc - we_start) * T, CW_NS);
            chk("R5 addr hold", int'(ram_addr), int'(w_addr));
            chk("R5 data hold", int'(ram_dq_o), int'(w_data));
            chk("R5 driver hold", int'(ram_dq_oe), 1);
            mem[w_addr] = w_data;
         end
         prev_rd   = rd_act;
         prev_wr   = wr_act;
         prev_addr = ram_addr;
      end
   end

   // ---------------- request driver ----------------
   task automatic do_op(input logic wr, input logic [14:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!done) begin
         @(negedge clk);
         lat++;
      end
      rd = rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         errors++;
         $display("FAIL R7 watchdog actual=%0d expected=done", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0]  rd;
      logic [15:0] lfsr;
      int          lat;
      int          dcount;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 cs_n", int'(ram_cs_n), 1);
      chk("R1 oe_n", int'(ram_oe_n), 1);
      chk("R1 we_n", int'(ram_we_n), 1);
      chk("R1 dq_oe", int'(ram_dq_oe), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 ready", int'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after release", int'(req_ready), 1);

      // table walk: R3 read data/latency, R5 write latency
      for (int i = 0; i < NV; i++) begin
         do_op(VEC[i].wr, VEC[i].addr, VEC[i].data, rd, lat);
         if (VEC[i].wr) begin
            chk("R5 write done latency", lat, WR_LAT);
         end else begin
            chk("R3 read data", int'(rd), int'(VEC[i].data));
            chk("R3 read done latency", lat, RD_LAT);
         end
         @(negedge clk);
         chk("R7 done one cycle", int'(done), 0);
      end

      // R6: ready low for two cycles starting with the done cycle
      do_op(1'b0, 15'h4AA5, 8'h00, rd, lat);
      chk("R6 ready in done cycle", int'(req_ready), 0);
      // R7: request offered while not ready is ignored
      req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0000; req_wdata = 8'h99;
      @(negedge clk);
      chk("R6 ready second cycle", int'(req_ready), 0);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R6 ready back", int'(req_ready), 1);
      dcount = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (done || !ram_we_n) dcount++;
      end
      chk("R7 ignored request no activity", dcount, 0);
      do_op(1'b0, 15'h0000, 8'h00, rd, lat);
      chk("R7 ignored request left RAM", int'(rd), 8'h5A);

      // read end and pending write meet: valid held, request switched to write
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h7FFF;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_write = 1'b1; req_addr = 15'h2222; req_wdata = 8'hA7;
      while (!done) @(negedge clk);
      chk("R3 read before pending write", int'(rdata), 8'hC3);
      chk("R6 pending write held off", int'(ram_dq_oe), 0);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!done) begin @(negedge clk); lat++; end
      chk("R5 pending write latency", lat, WR_LAT);
      do_op(1'b0, 15'h2222, 8'h00, rd, lat);
      chk("R3 pending write readback", int'(rd), 8'hA7);

      // pseudo-random write/readback
      lfsr = 16'hACE1;
      for (int n = 0; n < 12; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         do_op(1'b1, lfsr[14:0], lfsr[7:0] ^ 8'h3C, rd, lat);
         do_op(1'b0, lfsr[14:0], 8'h00, rd, lat);
         chk("R3 random readback", int'(rd), int'(lfsr[7:0] ^ 8'h3C));
      end

      fin = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule